// File: doc/BRIEF.md
# Compare-Clear Up-Counter Timer Channel

This block is one channel of an up-counting timer. A counter advances by one on every cycle where the count tick input is high and the run bit is set. Two compare registers, A and B, are checked against the counter whenever it advances. Each match raises its own sticky flag. Software can pick one of the two compare registers as the clear source. The counter then restarts from zero after reaching that value, so the channel becomes a periodic counter whose period is set by the chosen register. With no clear source chosen, the counter runs freely and wraps from all-ones to zero. The wrap raises a sticky overflow flag.

Software uses a small write/read register port. Through it, software sets the run bit and the clear source, loads the compare values and the counter, sets the three interrupt enables, and reads or clears the flags. A single interrupt request output is high while any enabled flag is set. The three flags are also brought out directly.

Top module: `cmpTimerChannel`

## Requirements
- R1: After reset, the counter is 0 and the run bit is 0. The clear source is "none", so the channel is free-running. Both compare registers are 0xFFFF, all interrupt enables are 0, and all flags are 0.
- R2: The counter rises by exactly 1 on each clock edge where `cntTick` is 1 and the run bit is 1. While the run bit is 0, the counter holds its value and no flag is set, whatever `cntTick` does.
- R3: When the counter advances from 0xFFFF without being cleared, it becomes 0x0000, the overflow flag is set (bit 2 of the flag register), and counting goes on from 0x0000.
- R4: The clear-source field is bits [2:1] of the control register (address 0), and the run bit is bit 0. The field values are: 00 = no clear, 01 = clear on a match with A, 10 = clear on a match with B, 11 = no clear.
- R5: Matches are judged on the counter value before it advances. A match with A sets flag bit 0, and a match with B sets flag bit 1. Both happen whatever the clear source is.
- R6: On a match with the selected clear-source register, the counter is 0x0000 after that edge. Later ticks count up from there.
- R7: The flags sit in the flag register at address 5 and are sticky. Writing a 0 to a flag bit clears it, and writing a 1 leaves it unchanged. If a hardware set and a software clear of the same flag happen in the same cycle, the flag ends up set.
- R8: The enable register is at address 4: bit 0 enables A, bit 1 enables B, bit 2 enables overflow. `irq` is 1 exactly when some flag is set and its enable bit is 1.
- R9: Compare A is at address 1, compare B at address 2, and the counter at address 3. All registers read back on `rdData`. A write to the counter takes the written value even if a tick comes in the same cycle, and that cycle sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | Count enable tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Read data for rdAddr |
| flagOvf | output | 1 | Sticky overflow flag |
| flagMatchA | output | 1 | Sticky compare-A match flag |
| flagMatchB | output | 1 | Sticky compare-B match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks the counter across the 0xFFFF wrap with both compares still at their reset value 0xFFFF, so a single edge must raise all three flags. A design that only flags the wrap, or clears wrongly, would show a different flag pattern.

The bench runs a periodic cycle against A and then against B, with the other compare lying inside the period. If the clear decode is wrong, the design would restart at the wrong value. If it skips the non-selected flag, flag bit 0 would read 0. The reserved clear code is also driven, and a design that treats it as a live clear would return to 0 at the compare.

Two same-cycle races are forced: a flag clear against a hardware set (the flag must stay set), and a counter write against a tick (the written value must appear, not that value plus one). A stopped counter that is still fed ticks must neither move nor raise a flag.

// File: rtl/cmpTimerPkg.sv
package cmpTimerPkg;
  localparam int REG_ADDR_W = 3;
  typedef logic [REG_ADDR_W-1:0] regAddr_t;

  localparam regAddr_t ADR_CTRL   = 3'd0;
  localparam regAddr_t ADR_CMPA   = 3'd1;
  localparam regAddr_t ADR_CMPB   = 3'd2;
  localparam regAddr_t ADR_COUNT  = 3'd3;
  localparam regAddr_t ADR_IEN    = 3'd4;
  localparam regAddr_t ADR_STATUS = 3'd5;

  localparam int NUM_CMP = 2;
  localparam int NUM_FLAG = 3;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSVD = 2'b11
  } clrSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic load;
    logic clrOnA;
    logic clrOnB;
  } cmdStrobes_t;

  // events from datapath back to control
  typedef struct packed {
    logic wrap;
    logic hitB;
    logic hitA;
  } cntEvents_t;
endpackage

// File: rtl/cmpTimerDatapath.sv
module cmpTimerDatapath
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobes_t      cmd,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpAVal,
  input  logic [CNT_W-1:0] cmpBVal,
  output logic [CNT_W-1:0] countVal,
  output cntEvents_t       events
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cmpVals [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] clrEn;
  logic doClear;
  logic [CNT_W-1:0] countNext;

  assign cmpVals[0] = cmpAVal;
  assign cmpVals[1] = cmpBVal;
  assign clrEn = {cmd.clrOnB, cmd.clrOnA};

  // one comparator per compare register, judged on the pre-advance value
  for (genvar i = 0; i < NUM_CMP; i++) begin : gCmp
    assign hit[i] = cmd.countEn && (countVal == cmpVals[i]);
  end

  assign doClear = |(hit & clrEn);

  always_comb begin
    events.hitA = hit[0];
    events.hitB = hit[1];
    events.wrap = cmd.countEn && !doClear && (countVal == CNT_MAX);
  end

  always_comb begin
    if (cmd.load)         countNext = loadVal;
    else if (doClear)     countNext = '0;
    else if (cmd.countEn) countNext = countVal + CNT_ONE;
    else                  countNext = countVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) countVal <= '0;
    else       countVal <= countNext;
  end
endmodule

// File: rtl/cmpTimerCtrl.sv
module cmpTimerCtrl
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             wrEn,
  input  regAddr_t         wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  regAddr_t         rdAddr,
  input  logic [CNT_W-1:0] countVal,
  input  cntEvents_t       events,
  output cmdStrobes_t      cmd,
  output logic [CNT_W-1:0] rdData,
  output logic             runBit,
  output clrSel_e          clrSel,
  output logic [CNT_W-1:0] cmpAVal,
  output logic [CNT_W-1:0] cmpBVal,
  output logic [NUM_FLAG-1:0] ieBits,
  output logic [NUM_FLAG-1:0] flags,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

  logic wrCtrl, wrCmpA, wrCmpB, wrCount, wrIen, wrStatus;
  logic [NUM_FLAG-1:0] setVec;
  logic [NUM_FLAG-1:0] flagsNext;

  assign wrCtrl   = wrEn && (wrAddr == ADR_CTRL);
  assign wrCmpA   = wrEn && (wrAddr == ADR_CMPA);
  assign wrCmpB   = wrEn && (wrAddr == ADR_CMPB);
  assign wrCount  = wrEn && (wrAddr == ADR_COUNT);
  assign wrIen    = wrEn && (wrAddr == ADR_IEN);
  assign wrStatus = wrEn && (wrAddr == ADR_STATUS);

  always_comb begin
    cmd.load    = wrCount;
    cmd.countEn = runBit && cntTick && !wrCount;
    cmd.clrOnA  = (clrSel == CLR_ON_A);
    cmd.clrOnB  = (clrSel == CLR_ON_B);
  end

  assign setVec = {events.wrap, events.hitB, events.hitA};

  // write-zero clears; a same-cycle hardware set wins
  always_comb begin
    flagsNext = flags;
    if (wrStatus) flagsNext = flags & wrData[NUM_FLAG-1:0];
    flagsNext = flagsNext | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      clrSel  <= CLR_NONE;
      cmpAVal <= CMP_RST;
      cmpBVal <= CMP_RST;
      ieBits  <= '0;
      flags   <= '0;
    end else begin
      if (wrCtrl) begin
        runBit <= wrData[0];
        clrSel <= clrSel_e'(wrData[2:1]);
      end
      if (wrCmpA) cmpAVal <= wrData;
      if (wrCmpB) cmpBVal <= wrData;
      if (wrIen)  ieBits  <= wrData[NUM_FLAG-1:0];
      flags <= flagsNext;
    end
  end

  assign irq = |(flags & ieBits);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_CTRL:   rdData[2:0] = {clrSel, runBit};
      ADR_CMPA:   rdData = cmpAVal;
      ADR_CMPB:   rdData = cmpBVal;
      ADR_COUNT:  rdData = countVal;
      ADR_IEN:    rdData[NUM_FLAG-1:0] = ieBits;
      ADR_STATUS: rdData[NUM_FLAG-1:0] = flags;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/cmpTimerChannel.sv
module cmpTimerChannel
  import cmpTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             flagOvf,
  output logic             flagMatchA,
  output logic             flagMatchB,
  output logic             irq
);
  cmdStrobes_t         cmd;
  cntEvents_t          events;
  logic [CNT_W-1:0]    countVal;
  logic [CNT_W-1:0]    cmpAVal;
  logic [CNT_W-1:0]    cmpBVal;
  logic                runBit;
  clrSel_e             clrSel;
  logic [NUM_FLAG-1:0] ieBits;
  logic [NUM_FLAG-1:0] flags;

  cmpTimerCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .countVal(countVal), .events(events), .cmd(cmd), .rdData(rdData),
    .runBit(runBit), .clrSel(clrSel), .cmpAVal(cmpAVal), .cmpBVal(cmpBVal),
    .ieBits(ieBits), .flags(flags), .irq(irq)
  );

  cmpTimerDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(wrData),
    .cmpAVal(cmpAVal), .cmpBVal(cmpBVal),
    .countVal(countVal), .events(events)
  );

  assign flagMatchA = flags[0];
  assign flagMatchB = flags[1];
  assign flagOvf    = flags[2];
endmodule

// File: rtl/cmpTimerChecker.sv
module cmpTimerChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] countVal,
  input logic             runBit,
  input logic [1:0]       clrSel,
  input logic [CNT_W-1:0] cmpAVal,
  input logic [CNT_W-1:0] cmpBVal,
  input logic [2:0]       ieBits,
  input logic             flagOvf,
  input logic             flagMatchA,
  input logic             flagMatchB,
  input logic             irq
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};
  logic ldCnt, wrStat, step, clrHit;
  assign ldCnt  = wrEn && (wrAddr == 3'd3);
  assign wrStat = wrEn && (wrAddr == 3'd5);
  assign step   = runBit && cntTick && !ldCnt;
  assign clrHit = (clrSel == 2'b01 && countVal == cmpAVal) ||
                  (clrSel == 2'b10 && countVal == cmpBVal);

  AST_RESET_FREE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (clrSel == 2'b00 && !runBit && countVal == '0)); // R1
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !ldCnt) |=> $stable(countVal)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (step && !clrHit && countVal != ALL1) |=> countVal == $past(countVal) + 1'b1); // R2
  AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (step && !clrHit && countVal == ALL1) |=> (countVal == '0 && flagOvf)); // R3
  AST_RESERVED_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (step && clrSel == 2'b11 && countVal == cmpAVal && countVal != ALL1) |=> countVal != '0); // R4
  AST_MATCH_B_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (step && countVal == cmpBVal) |=> flagMatchB); // R5
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (step && clrHit) |=> countVal == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagOvf && !wrStat) |=> flagOvf); // R7
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ((flagMatchA && ieBits[0]) || (flagMatchB && ieBits[1]) || (flagOvf && ieBits[2])) |-> irq); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ldCnt |=> countVal == $past(wrData)); // R9
endmodule

bind cmpTimerChannel cmpTimerChecker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .countVal(countVal), .runBit(runBit), .clrSel(clrSel),
  .cmpAVal(cmpAVal), .cmpBVal(cmpBVal), .ieBits(ieBits), .flagOvf(flagOvf),
  .flagMatchA(flagMatchA), .flagMatchB(flagMatchB), .irq(irq)
);

// File: tb/tb_cmpTimerChannel.sv
`timescale 1ns/100ps
module tb_cmpTimerChannel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [15:0] rdData;
  logic flagOvf, flagMatchA, flagMatchB, irq;

  cmpTimerChannel dut (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .flagOvf(flagOvf),
    .flagMatchA(flagMatchA), .flagMatchB(flagMatchB), .irq(irq)
  );

  always #2 clk = ~clk;

  localparam int SEL_OUT = 8; // {irq, ovf, matchB, matchA}
  typedef struct { int sel; logic [15:0] exp; string tag; } item_t;
  item_t sbq[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      item_t it;
      logic [15:0] act;
      wait (sbq.size() != 0);
      #0.5;
      it = sbq.pop_front();
      act = (it.sel == SEL_OUT) ? {12'd0, irq, flagOvf, flagMatchB, flagMatchA} : rdData;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic expectVal(input int sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    if (sel != SEL_OUT) rdAddr = sel[2:0];
    sbq.push_back('{sel, exp, tag});
    wait (sbq.size() == 0);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic wrWithTick(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; cntTick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cntTick = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectVal(3, 16'h0000, "R1 count");
    expectVal(0, 16'h0000, "R1 ctrl");
    expectVal(1, 16'hFFFF, "R1 cmpA");
    expectVal(2, 16'hFFFF, "R1 cmpB");
    expectVal(5, 16'h0000, "R1 status");
    expectVal(SEL_OUT, 16'h0, "R1 outputs");
    // R2 stopped counter ignores ticks
    ticks(5);
    expectVal(3, 16'h0000, "R2 stopped count");
    wr(3'd0, 16'h0001);
    ticks(10);
    expectVal(3, 16'd10, "R2 running count");
    // R9 counter load, R3 wrap with compares at FFFF -> all three flags
    wr(3'd3, 16'hFFFD);
    expectVal(3, 16'hFFFD, "R9 count readback");
    ticks(5);
    expectVal(3, 16'h0002, "R3 continue after wrap");
    expectVal(5, 16'h0007, "R3 ovf and R5 matches");
    expectVal(SEL_OUT, 16'h7, "R8 no enables no irq");
    wr(3'd4, 16'h0004);
    expectVal(SEL_OUT, 16'hF, "R8 ovf enabled irq");
    wr(3'd5, 16'h0003);
    expectVal(5, 16'h0003, "R7 write zero clears ovf only");
    expectVal(SEL_OUT, 16'h3, "R8 irq drops with ovf");
    wr(3'd5, 16'h0000);
    expectVal(5, 16'h0000, "R7 clear all");
    // R6 periodic on A
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd6);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0003);
    expectVal(0, 16'h0003, "R4 ctrl readback");
    ticks(4);
    expectVal(3, 16'd4, "R6 reached A");
    expectVal(5, 16'h0000, "R5 no flag before judged");
    ticks(1);
    expectVal(3, 16'd0, "R6 cleared on A");
    expectVal(5, 16'h0001, "R5 A flag");
    ticks(2);
    expectVal(3, 16'd2, "R6 counts on after clear");
    // R4 clear on B, A still flags
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0005);
    ticks(5);
    expectVal(3, 16'd0, "R4 cleared on B");
    expectVal(5, 16'h0003, "R5 both flags in B period");
    wr(3'd4, 16'h0002);
    expectVal(SEL_OUT, 16'hB, "R8 B enabled irq");
    // R4 reserved code does not clear
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0007);
    wr(3'd3, 16'd3);
    ticks(5);
    expectVal(3, 16'd8, "R4 reserved no clear");
    expectVal(5, 16'h0003, "R5 flags with reserved code");
    // R7 set wins over same-cycle clear
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'd4);
    wrWithTick(3'd5, 16'h0000);
    expectVal(5, 16'h0001, "R7 set wins");
    expectVal(3, 16'd0, "R6 clear during status write");
    // R9 load beats tick
    wr(3'd5, 16'h0000);
    wr(3'd0, 16'h0001);
    wrWithTick(3'd3, 16'h0050);
    expectVal(3, 16'h0050, "R9 load wins over tick");
    expectVal(5, 16'h0000, "R9 no flag on load cycle");
    // R2 stopped at a match sets no flags
    wr(3'd0, 16'h0002);
    wr(3'd3, 16'd4);
    ticks(3);
    expectVal(3, 16'd4, "R2 stopped at match holds");
    expectVal(5, 16'h0000, "R2 stopped no flags");
    // R7 write ones has no effect
    wr(3'd5, 16'h0007);
    expectVal(5, 16'h0000, "R7 write one no set");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule